// File: doc/BRIEF.md
# Conversion-start serial ADC reader

This block is the host-side sequencer for a sampling converter that has only three digital lines: a conversion-start output, a shift clock output and a serial data input. The converter has no chip select. The start line does that job. A rising edge on it begins a conversion. While it is high the converter is busy. When it goes low the converter drives its data line and starts acquiring the next sample. The reader raises the start line and holds it high for the conversion time. It then lowers the line, waits a short setup gap and clocks out a frame of 12 or 16 bits. The finished 12-bit word is presented with a one-cycle strobe.

A conversion is requested in one of two ways: a pulse on `start_req`, or an internal rate tick that fires every `auto_period` clocks while `auto_en` is high. All timing counts are derived at elaboration from the system clock frequency and the converter's minimum times:

- conversion hold
- acquisition gap
- setup before the first shift-clock edge
- shift-clock half period

Settings that would break a minimum stop elaboration. The result is a plain pulse with no back-pressure: `data_valid` is high for exactly one cycle, and the receiver must take `data_word` in that cycle.

Top module: `conv_adc_reader`

## Requirements
- R1: After reset, `conv_o`, `sck_o`, `busy`, `data_valid` and `pad_err` are all low.
- R2: An accepted request drives `conv_o` high for exactly CONV_CYC clocks, where CONV_CYC = ceil(CONV_NS·CLK_HZ/1e9) (150 at the defaults).
- R3: `conv_o` never rises until it has been low for at least ACQ_CYC clocks (ceil(ACQ_NS·CLK_HZ/1e9), 50 at the defaults), and this includes the interval after reset. A request that arrives earlier waits.
- R4: `sck_o` is low whenever `conv_o` is high or the reader is idle. Each high phase of `sck_o` lasts HALF clocks and each low phase lasts at least HALF clocks, where HALF = ceil(CLK_HZ/(2·SCK_HZ)). Its first rising edge comes at least SETUP_CYC + HALF clocks after `conv_o` falls.
- R5: Every conversion produces exactly FRAME_BITS rising edges on `sck_o`. The bit on `sdo_i` is sampled at each rising edge. The first 12 samples form the word with the most significant bit first, so bit 11 is the first sample.
- R6: `data_valid` is a single-cycle pulse. It arrives on the same clock as the last falling `sck_o` edge, which is CONV_CYC + SETUP_CYC + 2·FRAME_BITS·HALF clocks after the cycle that accepted the request (216 at the defaults).
- R7: With a 16-bit frame, the bits sampled at rising edges 13 to 16 must be zero. `pad_err` is high together with `data_valid` when any of them is one, and low otherwise. `pad_err` is never high without `data_valid`.
- R8: `busy` is high from the clock after a request until the last falling `sck_o` edge. Requests that arrive while the reader is busy merge into one pending conversion, which starts on the clock after `data_valid`.
- R9: While `auto_en` is high, the rate tick requests a conversion once every `auto_period` clocks. When the period is longer than a conversion, successive `conv_o` rising edges are exactly `auto_period` clocks apart.
- R10: Elaboration fails if FRAME_BITS is neither 12 nor 16, or if 2·HALF clock periods are shorter than MIN_SCK_NS. The shift clock has a 50% duty cycle, so each phase is well above 40% of its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request for a conversion |
| auto_en | input | 1 | Enables the periodic rate tick |
| auto_period | input | PERIOD_W | Tick period in clocks |
| conv_o | output | 1 | Conversion-start line, also the converter's output enable when low |
| sck_o | output | 1 | Shift clock to the converter, idle low |
| sdo_i | input | 1 | Serial data from the converter |
| busy | output | 1 | A conversion is running or pending |
| data_valid | output | 1 | One-cycle result strobe |
| data_word | output | DATA_BITS | Converted word, valid with `data_valid` |
| pad_err | output | 1 | A padding bit read as one, valid with `data_valid` |

## Verification
The bench builds the reader with a 100 MHz clock, a 25 MHz shift-clock target and a 16-bit frame. This gives a conversion hold of 150 clocks, an acquisition gap of 50 clocks, a setup gap of 2 clocks and a half period of 2 clocks. The four padding bits are present, so a converter model can inject nonzero pad patterns and exercise the error flag. Because the acquisition gap is shorter than the shift phase, back-to-back conversions start on the clock after each result. Requests fired soon after a result, or just after reset, still reach the acquisition wait. Rate periods of 400 and 100 clocks cover both the free-running tick and the case where ticks merge while the reader is busy.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SETUP = 2'd2,
    ST_SHIFT = 2'd3
  } rd_state_t;

  // Clocks needed to cover a time in ns, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned hz, input int unsigned ns);
    longint unsigned prod;
    longint unsigned r;
    prod = 64'(hz) * 64'(ns);
    r    = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    return (r == 64'd0) ? 1 : int'(r[31:0]);
  endfunction

  // Clocks per shift-clock phase, rounded up so the rate never exceeds the target.
  function automatic int unsigned half_div(input int unsigned hz, input int unsigned sck_hz);
    longint unsigned den;
    longint unsigned r;
    den = 64'(sck_hz) * 64'd2;
    r   = (64'(hz) + den - 64'd1) / den;
    return (r == 64'd0) ? 1 : int'(r[31:0]);
  endfunction

endpackage

// File: rtl/rd_down_timer.sv
module rd_down_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/rd_sck_gen.sv
module rd_sck_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int unsigned HC_W = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [HC_W-1:0] LIM = HC_W'(HALF - 1);

  logic [HC_W-1:0] hc;
  logic            toggle;

  assign toggle   = run && (hc == LIM);
  assign rise_stb = toggle && !sck;
  assign fall_stb = toggle && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc  <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      hc  <= '0;
      sck <= 1'b0;
    end else if (toggle) begin
      hc  <= '0;
      sck <= ~sck;
    end else begin
      hc  <= hc + 1'b1;
    end
  end

endmodule

// File: rtl/rd_rate_tick.sv
module rd_rate_tick #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic          tick
);

  logic [PW-1:0] cnt;
  logic [PW:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign tick = en && (nxt >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || tick) begin
      cnt <= '0;
    end else begin
      cnt <= nxt[PW-1:0];
    end
  end

endmodule

// File: rtl/rd_frame_capture.sv
module rd_frame_capture #(
  parameter int unsigned DATA_BITS  = 12,
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 sdo_i,
  output logic [DATA_BITS-1:0] word,
  output logic                 pad_bad,
  output logic                 last_fall
);

  localparam int unsigned BC_W = $clog2(FRAME_BITS + 1);
  localparam logic [BC_W-1:0] LAST_IDX = BC_W'(FRAME_BITS - 1);
  localparam logic [BC_W-1:0] DATA_END = BC_W'(DATA_BITS);

  logic [BC_W-1:0] bcnt;
  logic            in_data;

  assign in_data   = (bcnt < DATA_END);
  assign last_fall = fall_stb && (bcnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
    end else if (clear) begin
      bcnt <= '0;
    end else if (fall_stb) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (rise_stb && in_data) begin
      word <= {word[DATA_BITS-2:0], sdo_i};
    end
  end

  generate
    if (FRAME_BITS > DATA_BITS) begin : g_pad
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pad_bad <= 1'b0;
        end else if (clear) begin
          pad_bad <= 1'b0;
        end else if (rise_stb && !in_data && sdo_i) begin
          pad_bad <= 1'b1;
        end
      end
    end else begin : g_nopad
      assign pad_bad = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/conv_adc_reader.sv
module conv_adc_reader
  import conv_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SCK_HZ     = 25_000_000,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned DATA_BITS  = 12,
  parameter int unsigned CONV_NS    = 1500,
  parameter int unsigned ACQ_NS     = 500,
  parameter int unsigned SETUP_NS   = 16,
  parameter int unsigned MIN_SCK_NS = 20,
  parameter int unsigned PERIOD_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 auto_en,
  input  logic [PERIOD_W-1:0]  auto_period,
  output logic                 conv_o,
  output logic                 sck_o,
  input  logic                 sdo_i,
  output logic                 busy,
  output logic                 data_valid,
  output logic [DATA_BITS-1:0] data_word,
  output logic                 pad_err
);

  localparam int unsigned CONV_CYC  = ns_to_cyc(CLK_HZ, CONV_NS);
  localparam int unsigned ACQ_CYC   = ns_to_cyc(CLK_HZ, ACQ_NS);
  localparam int unsigned SETUP_CYC = ns_to_cyc(CLK_HZ, SETUP_NS);
  localparam int unsigned HALF      = half_div(CLK_HZ, SCK_HZ);
  localparam int unsigned TIM_W     = $clog2(CONV_CYC + SETUP_CYC + 1);
  localparam int unsigned ACQ_W     = $clog2(ACQ_CYC + 1);
  localparam longint unsigned SCK_SPAN = 64'(2 * HALF) * 64'd1_000_000_000;
  localparam longint unsigned SCK_MIN  = 64'(MIN_SCK_NS) * 64'(CLK_HZ);

  // Elaboration guards (R10)
  generate
    if (FRAME_BITS != 12 && FRAME_BITS != 16) begin : g_bad_frame
      $error("conv_adc_reader: frame length must be 12 or 16 clocks");
    end
    if (SCK_SPAN < SCK_MIN) begin : g_bad_sck
      $error("conv_adc_reader: shift clock period below the minimum");
    end
    if (DATA_BITS > FRAME_BITS) begin : g_bad_data
      $error("conv_adc_reader: data width exceeds frame length");
    end
  endgenerate

  rd_state_t state;
  logic      pend;
  logic      launch;
  logic      tick;
  logic      t_load;
  logic      t_zero;
  logic      acq_load;
  logic      acq_zero;
  logic [TIM_W-1:0] t_val;
  logic      sck_run;
  logic      rise_stb;
  logic      fall_stb;
  logic      last_fall;
  logic      cap_pad;
  logic [DATA_BITS-1:0] cap_word;

  assign launch   = (state == ST_IDLE) && acq_zero && (pend || start_req || tick);
  assign t_load   = launch || ((state == ST_CONV) && t_zero);
  assign t_val    = launch ? TIM_W'(CONV_CYC - 1) : TIM_W'(SETUP_CYC - 1);
  assign acq_load = (state == ST_CONV) && t_zero;
  assign sck_run  = (state == ST_SHIFT);
  assign busy     = (state != ST_IDLE) || pend;

  rd_rate_tick #(.PW(PERIOD_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (auto_en),
    .period (auto_period),
    .tick   (tick)
  );

  rd_down_timer #(.W(TIM_W), .RST_VAL(0)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  rd_down_timer #(.W(ACQ_W), .RST_VAL(ACQ_CYC - 1)) u_acq_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acq_load),
    .load_val (ACQ_W'(ACQ_CYC - 1)),
    .zero     (acq_zero)
  );

  rd_sck_gen #(.HALF(HALF)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sck_run),
    .sck      (sck_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  rd_frame_capture #(.DATA_BITS(DATA_BITS), .FRAME_BITS(FRAME_BITS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .sdo_i     (sdo_i),
    .word      (cap_word),
    .pad_bad   (cap_pad),
    .last_fall (last_fall)
  );

  // Request merging (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      pend <= (pend || start_req || tick) && !launch;
    end
  end

  // Sequencer (R2, R3, R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      conv_o     <= 1'b0;
      data_valid <= 1'b0;
      data_word  <= '0;
      pad_err    <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      pad_err    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state  <= ST_CONV;
            conv_o <= 1'b1;
          end
        end
        ST_CONV: begin
          if (t_zero) begin
            state  <= ST_SETUP;
            conv_o <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (t_zero) begin
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (last_fall) begin
            state      <= ST_IDLE;
            data_valid <= 1'b1;
            data_word  <= cap_word;
            pad_err    <= cap_pad;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/conv_adc_reader_chk.sv
module conv_adc_reader_chk #(
  parameter int unsigned CONV_CYC   = 150,
  parameter int unsigned ACQ_CYC    = 50,
  parameter int unsigned HALF       = 2,
  parameter int unsigned FRAME_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic conv_o,
  input logic sck_o,
  input logic busy,
  input logic data_valid,
  input logic pad_err
);

  logic [15:0] hi_cnt;
  logic [15:0] lo_cnt;
  logic [15:0] sh_cnt;
  logic [15:0] sl_cnt;
  logic [7:0]  rc;
  logic        sck_q;
  logic        conv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      sh_cnt <= '0;
      sl_cnt <= '0;
      rc     <= '0;
      sck_q  <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      sck_q  <= sck_o;
      conv_q <= conv_o;
      hi_cnt <= conv_o ? ((hi_cnt == 16'hffff) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= conv_o ? '0 : ((lo_cnt == 16'hffff) ? lo_cnt : lo_cnt + 1'b1);
      sh_cnt <= sck_o ? ((sh_cnt == 16'hffff) ? sh_cnt : sh_cnt + 1'b1) : '0;
      sl_cnt <= sck_o ? '0 : ((sl_cnt == 16'hffff) ? sl_cnt : sl_cnt + 1'b1);
      if (conv_q && !conv_o) rc <= '0;
      else if (sck_o && !sck_q) rc <= rc + 1'b1;
    end
  end

  a_r2_conv_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> hi_cnt == 16'(CONV_CYC));

  a_r3_acq_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> lo_cnt >= 16'(ACQ_CYC));

  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_o || !busy) |-> !sck_o);

  a_r4_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> sh_cnt == 16'(HALF));

  a_r4_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> sl_cnt >= 16'(HALF));

  a_r5_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> rc == 8'(FRAME_BITS));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  a_r6_valid_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (!sck_o && $past(sck_o)));

  a_r7_pad_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pad_err |-> data_valid);

  a_r8_busy_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> busy);

endmodule

bind conv_adc_reader conv_adc_reader_chk #(
  .CONV_CYC   (CONV_CYC),
  .ACQ_CYC    (ACQ_CYC),
  .HALF       (HALF),
  .FRAME_BITS (FRAME_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_o     (conv_o),
  .sck_o      (sck_o),
  .busy       (busy),
  .data_valid (data_valid),
  .pad_err    (pad_err)
);

// File: tb/conv_adc_reader_bench.sv
`timescale 1ns/1ps
module conv_adc_reader_bench;

  localparam int CLK_PERIOD_NS = 10;
  localparam int CLK_HZ  = 100_000_000;
  localparam int SCK_HZ  = 25_000_000;
  localparam int FRAME   = 16;
  localparam int CONV_C  = (CLK_HZ / 1000 * 1500 + 999_999) / 1_000_000;
  localparam int ACQ_C   = (CLK_HZ / 1000 * 500 + 999_999) / 1_000_000;
  localparam int SETUP_C = (CLK_HZ / 1000 * 16 + 999_999) / 1_000_000;
  localparam int HALF_C  = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);
  localparam int LAT     = CONV_C + SETUP_C + 2 * FRAME * HALF_C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        auto_en = 1'b0;
  logic [15:0] auto_period = 16'd0;
  logic        conv_o, sck_o, busy, data_valid, pad_err;
  logic        sdo = 1'b0;
  logic [11:0] data_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  conv_adc_reader #(
    .CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .FRAME_BITS(FRAME)
  ) u_conv_adc_reader (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_en(auto_en),
    .auto_period(auto_period), .conv_o(conv_o), .sck_o(sck_o), .sdo_i(sdo),
    .busy(busy), .data_valid(data_valid), .data_word(data_word), .pad_err(pad_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model: word chosen at the start edge, MSB driven when the start line drops.
  bit         force_en = 1'b0;
  logic [11:0] force_word = '0;
  logic [3:0]  pad_inject = '0;
  logic [11:0] m_word = '0;
  logic [3:0]  m_pad = '0;
  int          idx = 0;

  always @(posedge conv_o) begin
    m_word = force_en ? force_word : 12'($urandom);
    m_pad  = pad_inject;
  end
  always @(negedge conv_o) begin
    idx = 0;
    sdo = m_word[11];
  end
  always @(negedge sck_o) begin
    if (!conv_o) begin
      idx = idx + 1;
      if (idx < 12)      sdo = m_word[11 - idx];
      else if (idx < 16) sdo = m_pad[15 - idx];
      else               sdo = 1'b0;
    end
  end

  // Monitor, sampling away from the active edge.
  int  mcyc = 0, hi_run = 0, lo_run = 0, sck_rises = 0, t_rise = 0, valids = 0;
  bit  conv_q = 0, sck_q = 0, valid_q = 0, sck_in_conv = 0, dbl_valid = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      mcyc++;
      if (conv_o && !conv_q) begin
        chk(lo_run >= ACQ_C - 1, "R3 acquisition gap", lo_run, ACQ_C);
        t_rise = mcyc;
        sck_rises = 0;
      end
      if (!conv_o && conv_q)
        chk(hi_run == CONV_C, "R2 conversion hold", hi_run, CONV_C);
      if (sck_o && !sck_q) sck_rises++;
      if (conv_o && sck_o) sck_in_conv = 1;
      if (data_valid && valid_q) dbl_valid = 1;
      if (data_valid) begin
        valids++;
        chk(data_word == m_word, "R5 word", int'(data_word), int'(m_word));
        chk(pad_err == (m_pad != 0), "R7 pad flag", int'(pad_err), int'(m_pad != 0));
        chk(sck_rises == FRAME, "R5 frame clocks", sck_rises, FRAME);
        chk(mcyc - t_rise == LAT, "R6 latency", mcyc - t_rise, LAT);
      end
      if (conv_o) begin hi_run++; lo_run = 0; end
      else        begin lo_run++; hi_run = 0; end
      conv_q  = conv_o;
      sck_q   = sck_o;
      valid_q = data_valid;
    end
  end

  task automatic pulse_req();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic one_conv(input bit fe, input logic [11:0] w, input logic [3:0] pad);
    int v0;
    force_en = fe; force_word = w; pad_inject = pad;
    v0 = valids;
    pulse_req();
    wait (valids != v0);
    @(negedge clk);
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    while (quiet < 60) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic rate_run(input int period, input int exp_gap, input string req);
    int t_prev = 0;
    auto_period = 16'(period);
    auto_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge conv_o);
      @(negedge clk);
      if (k >= 2) chk(mcyc - t_prev == exp_gap, req, mcyc - t_prev, exp_gap);
      t_prev = mcyc;
    end
    auto_en = 1'b0;
    wait_quiet();
  endtask

  initial begin
    #(CLK_PERIOD_NS * 150_000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int v0;
    void'($urandom(32'h1bad5eed));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(conv_o == 0, "R1 conv", int'(conv_o), 0);
    chk(sck_o == 0, "R1 sck", int'(sck_o), 0);
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(data_valid == 0 && pad_err == 0, "R1 strobes", int'(data_valid), 0);
    rst_n = 1'b1;
    // R3: a request right after reset still waits for acquisition
    one_conv(1, 12'hFFF, 4'h0);
    @(negedge clk);
    chk(busy == 0, "R8 busy drops", int'(busy), 0);
    one_conv(1, 12'h000, 4'h0);
    one_conv(1, 12'h800, 4'h0);
    one_conv(1, 12'h001, 4'h1);   // R7 last pad bit set
    one_conv(1, 12'hA5C, 4'h8);   // R7 first pad bit set
    one_conv(1, 12'h5A3, 4'h0);
    // Random words, pads and gaps
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom % 40) @(negedge clk);
      one_conv(0, 12'h0, (($urandom % 4) == 0) ? 4'($urandom) : 4'h0);
    end
    // R8: requests during a conversion merge into one more
    wait_quiet();
    pad_inject = 4'h0; force_en = 0;
    v0 = valids;
    pulse_req();
    repeat (20) @(negedge clk);
    chk(busy == 1, "R8 busy during conversion", int'(busy), 1);
    pulse_req();
    repeat (30) @(negedge clk);
    pulse_req();
    repeat (100) @(negedge clk);
    pulse_req();
    wait (valids >= v0 + 2);
    repeat (500) @(negedge clk);
    chk(valids - v0 == 2, "R8 merged count", valids - v0, 2);
    chk(busy == 0, "R8 busy after merge", int'(busy), 0);
    // R9: periodic requests
    rate_run(400, 400, "R9 rate interval");
    rate_run(100, LAT + 1, "R9 R8 back-to-back interval");
    // R4 / R6 accumulated observations
    chk(sck_in_conv == 0, "R4 sck quiet while converting", int'(sck_in_conv), 0);
    chk(dbl_valid == 0, "R6 single-cycle valid", int'(dbl_valid), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule